// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns an asynchronous serial line into parallel characters. The line is resynchronised into the clock domain. It is then timed by an oversampling enable, `os_tick`, which runs at sixteen times the bit rate. Each bit is sampled near its centre.

The character shape is set by static configuration inputs:
- the data length, from 5 to 8 bits;
- whether a parity bit is present;
- whether parity is odd or even.

Bits arrive least significant first, after a single low start bit. When fewer than 8 bits are used, they land in the low end of the holding register and the upper bits are zero. The stop-bit count does not matter to this block, because only the first stop bit is examined.

A finished character is placed in the holding register at the middle of its first stop bit. At the same moment the done flag sets. The overrun, framing and parity error bits are also captured then, together with a summary error bit.

The host clears the done flag with a read strobe. A busy flag shows that a character is being assembled. A reader-run output is armed by the host and drops again at the next confirmed start bit, so an external character source advances by exactly one character. An interrupt request is raised while done and the receive interrupt enable are both high.

Top module: `rxu_top`

## Requirements
- R1: After reset, the following outputs are 0: `rx_done`, `rx_busy`, `rdr_run`, `rx_irq`, all error bits and `rx_data`.
- R2: A character of 5 + `cfg_len` data bits is taken least significant bit first, directly after a low start bit. With `cfg_len`=3 (8 bits) the full byte appears on `rx_data`.
- R3: With fewer than 8 data bits, the received bits occupy `rx_data[len-1:0]` and every higher bit of `rx_data` is 0.
- R4: `rx_done` rises in the middle of the first stop bit, and not earlier. It is still low 4 clocks into the stop bit and is high 14 clocks into it, at one tick per clock.
- R5: `rx_busy` rises once a start bit is confirmed and falls in the same cycle in which `rx_done` rises.
- R6: `err_ovr` is set when a new character completes while the previous one is still unread. It is cleared when the next character completes with no character pending.
- R7: `err_frm` is set when the first stop bit samples low, and cleared by a character whose stop bit is high.
- R8: When `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=1 selects odd parity, meaning data plus parity hold an odd count of ones; 0 selects even. `err_par` flags a mismatch. When `cfg_par_en`=0, no parity bit is expected and `err_par` stays 0.
- R9: `err_any` is the OR of the three error bits, and all of them are refreshed with each new character.
- R10: A one-cycle `host_rd` clears `rx_done` and leaves the data and error bits unchanged.
- R11: A `rdr_arm` pulse sets `rdr_run` and clears `rx_done`. `rdr_run` clears when the next start bit is confirmed.
- R12: `rx_irq` is high exactly while `rx_done` and `rx_ie` are both high.
- R13: A start bit is confirmed only if the line is still low on the 8th tick after the falling edge. A shorter low pulse leaves the receiver idle, with no busy and no character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 2 | Data length code: data bits = 5 + code |
| cfg_par_en | input | 1 | A parity bit follows the data |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| host_rd | input | 1 | Read strobe, clears the done flag |
| rdr_arm | input | 1 | Arms reader-run and clears done |
| rx_ie | input | 1 | Receive interrupt enable |
| rx_data | output | 8 | Holding register, right-justified |
| rx_done | output | 1 | A character is waiting |
| err_ovr | output | 1 | Overrun on the last character |
| err_frm | output | 1 | Framing error on the last character |
| err_par | output | 1 | Parity error on the last character |
| err_any | output | 1 | OR of the error bits |
| rx_busy | output | 1 | A character is being assembled |
| rdr_run | output | 1 | One-character reader advance |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The main function is driven with full bytes, with short 5-bit codes whose stimulus carries ones above the used length, and with both parity senses, each sense both correct and deliberately wrong. These patterns separate bit-order faults, justification faults and parity-sense faults. Back-to-back unread characters, followed by a read and a clean character, show whether overrun is both set and later cleared. A low stop bit and a short low glitch separate framing detection from start-bit qualification. Done timing is probed on both sides of the stop-bit centre, so that early and late flag updates are told apart.

// File: rtl/rxu_pkg.sv
package rxu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4
    } rx_state_e;

endpackage

// File: rtl/rxu_sync.sv
module rxu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: '1};
        else        s_q <= s_d;
    end

    assign sync_o = s_q.chain[STAGES-1];
endmodule

// File: rtl/rxu_deframer.sv
module rxu_deframer
    import rxu_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          rx_i,
    input  logic [1:0]    len_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    output logic          start_ok_o,
    output logic          chr_vld_o,
    output logic [DW-1:0] chr_data_o,
    output logic          chr_frm_o,
    output logic          chr_par_o
);
    localparam int CW      = $clog2(OVS);
    localparam int IW      = $clog2(DW);
    localparam int MIN_LEN = DW - 3;
    localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OVS - 1);

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] shf;
        logic          perr;
    } dfr_t;

    dfr_t r_d, r_q;
    logic [IW-1:0] last_idx;

    assign last_idx = IW'(MIN_LEN - 1) + IW'(len_i);

    always_comb begin
        r_d        = r_q;
        start_ok_o = 1'b0;
        chr_vld_o  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (tick_i && !rx_i) begin
                    r_d.st   = ST_START;
                    r_d.cnt  = '0;
                    r_d.idx  = '0;
                    r_d.shf  = '0;
                    r_d.perr = 1'b0;
                end
            end
            ST_START: begin
                if (tick_i) begin
                    if (rx_i) begin
                        r_d.st = ST_IDLE;
                    end else if (r_q.cnt == HALF) begin
                        r_d.st     = ST_DATA;
                        r_d.cnt    = '0;
                        start_ok_o = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL) begin
                        r_d.cnt = '0;
                        r_d.shf[r_q.idx] = rx_i;
                        if (r_q.idx == last_idx) begin
                            r_d.st = par_en_i ? ST_PAR : ST_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL) begin
                        r_d.cnt  = '0;
                        r_d.perr = ((^r_q.shf) ^ rx_i) != par_odd_i;
                        r_d.st   = ST_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick_i) begin
                    if (r_q.cnt == FULL) begin
                        chr_vld_o = 1'b1;
                        r_d.st    = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, cnt: '0, idx: '0, shf: '0, perr: 1'b0};
        else        r_q <= r_d;
    end

    assign chr_data_o = r_q.shf;
    assign chr_frm_o  = !rx_i;
    assign chr_par_o  = par_en_i && r_q.perr;

    // R5/R13: a start confirmation and a finished character never coincide
    p_start_vs_char_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ok_o, chr_vld_o}));

    // R8: with parity disabled no character carries a parity error
    p_no_par_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld_o && !par_en_i) |-> !chr_par_o);
endmodule

// File: rtl/rxu_top.sv
module rxu_top #(
    parameter int OVS   = 16,
    parameter int DW    = 8,
    parameter int SYNCS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rx_line,
    input  logic [1:0]    cfg_len,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          host_rd,
    input  logic          rdr_arm,
    input  logic          rx_ie,
    output logic [DW-1:0] rx_data,
    output logic          rx_done,
    output logic          err_ovr,
    output logic          err_frm,
    output logic          err_par,
    output logic          err_any,
    output logic          rx_busy,
    output logic          rdr_run,
    output logic          rx_irq
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          done;
        logic          ovr;
        logic          frm;
        logic          par;
        logic          busy;
        logic          rdr;
    } host_t;

    host_t h_d, h_q;

    logic          rx_s;
    logic          start_ok;
    logic          chr_vld;
    logic [DW-1:0] chr_data;
    logic          chr_frm;
    logic          chr_par;

    rxu_sync #(.STAGES(SYNCS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rx_line),
        .sync_o  (rx_s)
    );

    rxu_deframer #(.OVS(OVS), .DW(DW)) u_dfr (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (os_tick),
        .rx_i       (rx_s),
        .len_i      (cfg_len),
        .par_en_i   (cfg_par_en),
        .par_odd_i  (cfg_par_odd),
        .start_ok_o (start_ok),
        .chr_vld_o  (chr_vld),
        .chr_data_o (chr_data),
        .chr_frm_o  (chr_frm),
        .chr_par_o  (chr_par)
    );

    always_comb begin
        h_d = h_q;
        if (host_rd) h_d.done = 1'b0;
        if (rdr_arm) begin
            h_d.rdr  = 1'b1;
            h_d.done = 1'b0;
        end
        if (start_ok) begin
            h_d.busy = 1'b1;
            h_d.rdr  = 1'b0;
        end
        if (chr_vld) begin
            h_d.data = chr_data;
            h_d.ovr  = h_q.done && !host_rd && !rdr_arm;
            h_d.frm  = chr_frm;
            h_d.par  = chr_par;
            h_d.done = 1'b1;
            h_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign rx_data = h_q.data;
    assign rx_done = h_q.done;
    assign err_ovr = h_q.ovr;
    assign err_frm = h_q.frm;
    assign err_par = h_q.par;
    assign err_any = h_q.ovr | h_q.frm | h_q.par;
    assign rx_busy = h_q.busy;
    assign rdr_run = h_q.rdr;
    assign rx_irq  = h_q.done & rx_ie;

    // R4/R5: a finished character raises done and drops busy on the next edge
    p_done_with_char_r5: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld |=> (rx_done && !rx_busy));

    // R11: a confirmed start bit always leaves reader-run low
    p_reader_one_shot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> !rdr_run);

    // R12: an interrupt request implies a waiting character
    p_irq_needs_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_done);

    // R3: 5-bit characters leave the upper holding bits clear
    p_justify_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_vld && cfg_len == 2'd0) |=> (rx_data[DW-1:DW-3] == '0));

    // R10: a read strobe with no new character leaves the holding data alone
    p_read_keeps_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !chr_vld) |=> ($stable(rx_data) && !rx_done));
endmodule

// File: tb/tb_rxu_top.sv
module tb_rxu_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       host_rd = 1'b0;
    logic       rdr_arm = 1'b0;
    logic       rx_ie = 1'b0;
    logic [7:0] rx_data;
    logic       rx_done, err_ovr, err_frm, err_par, err_any;
    logic       rx_busy, rdr_run, rx_irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit busy_seen = 0;

    always #2 clk = ~clk;

    rxu_top dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .host_rd(host_rd), .rdr_arm(rdr_arm), .rx_ie(rx_ie),
        .rx_data(rx_data), .rx_done(rx_done), .err_ovr(err_ovr),
        .err_frm(err_frm), .err_par(err_par), .err_any(err_any),
        .rx_busy(rx_busy), .rdr_run(rdr_run), .rx_irq(rx_irq)
    );

    always @(negedge clk) if (rx_busy) busy_seen <= 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rx_line = v;
        repeat (16) @(negedge clk);
    endtask

    // Drives one frame; expect_clear means done is low when the frame begins
    task automatic send(input logic [7:0] val, input bit bad_par, input bit bad_stop,
                        input bit expect_clear);
        int n;
        logic p;
        n = 5 + int'(cfg_len);
        p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ val[i];
        p = p ^ cfg_par_odd ^ bad_par;
        bit_time(1'b0);
        check(rx_busy == 1'b1, "R5 busy after start", rx_busy, 1);
        check(rdr_run == 1'b0, "R11 reader-run cleared by start", rdr_run, 0);
        for (int i = 0; i < n; i++) bit_time(val[i]);
        if (cfg_par_en) bit_time(p);
        rx_line = ~bad_stop;
        repeat (4) @(negedge clk);
        if (expect_clear) check(rx_done == 1'b0, "R4 done not early", rx_done, 0);
        repeat (10) @(negedge clk);
        check(rx_done == 1'b1, "R4 done at mid stop", rx_done, 1);
        check(rx_busy == 1'b0, "R5 busy cleared with done", rx_busy, 0);
        repeat (2) @(negedge clk);
        bit_time(1'b1);
    endtask

    task automatic pulse_rd();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_done == 0 && rx_busy == 0 && rdr_run == 0 && rx_irq == 0,
              "R1 reset flags", {rx_done, rx_busy, rdr_run, rx_irq}, 0);
        check(err_any == 0 && rx_data == 0, "R1 reset data/errors", {err_any, rx_data}, 0);
        repeat (20) @(negedge clk);

        // R2: full byte, no parity
        send(8'hA5, 0, 0, 1);
        check(rx_data == 8'hA5, "R2 byte value", rx_data, 8'hA5);
        check(err_any == 0, "R9 clean char no error", err_any, 0);

        // R10: read clears done only
        pulse_rd();
        check(rx_done == 0, "R10 done cleared", rx_done, 0);
        check(rx_data == 8'hA5, "R10 data kept", rx_data, 8'hA5);

        // R3: 5-bit justification, stimulus has ones above bit 4
        cfg_len = 2'd0;
        send(8'hFB, 0, 0, 1);
        check(rx_data == 8'h1B, "R3 5-bit right-justified", rx_data, 8'h1B);
        pulse_rd();
        cfg_len = 2'd2;
        send(8'hC3, 0, 0, 1);
        check(rx_data == 8'h43, "R3 7-bit right-justified", rx_data, 8'h43);
        pulse_rd();

        // R8: even parity good then bad, odd parity good then bad
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h37, 0, 0, 1);
        check(err_par == 0 && rx_data == 8'h37, "R8 even parity ok", {err_par, rx_data}, 8'h37);
        pulse_rd();
        send(8'h37, 1, 0, 1);
        check(err_par == 1, "R8 even parity error", err_par, 1);
        check(err_any == 1, "R9 summary on parity", err_any, 1);
        pulse_rd();
        cfg_par_odd = 1'b1;
        send(8'h81, 0, 0, 1);
        check(err_par == 0 && rx_data == 8'h81, "R8 odd parity ok", {err_par, rx_data}, 8'h81);
        pulse_rd();
        send(8'h81, 1, 0, 1);
        check(err_par == 1, "R8 odd parity error", err_par, 1);
        pulse_rd();
        cfg_par_en = 1'b0;
        send(8'h5E, 0, 0, 1);
        check(err_par == 0 && rx_data == 8'h5E, "R8/R9 parity off, error refreshed",
              {err_par, rx_data}, 8'h5E);
        pulse_rd();

        // R7: framing error then recovery
        send(8'h3C, 0, 1, 1);
        check(err_frm == 1, "R7 low stop bit", err_frm, 1);
        check(err_any == 1, "R9 summary on framing", err_any, 1);
        pulse_rd();
        send(8'h3D, 0, 0, 1);
        check(err_frm == 0, "R7 framing cleared", err_frm, 0);
        pulse_rd();

        // R6: overrun then recovery
        send(8'h11, 0, 0, 1);
        send(8'h22, 0, 0, 0);
        check(err_ovr == 1 && rx_data == 8'h22, "R6 overrun set", {err_ovr, rx_data}, 9'h122);
        check(err_any == 1, "R9 summary on overrun", err_any, 1);
        pulse_rd();
        send(8'h33, 0, 0, 1);
        check(err_ovr == 0, "R6 overrun cleared", err_ovr, 0);

        // R12: interrupt follows done and enable
        rx_ie = 1'b1;
        @(negedge clk);
        check(rx_irq == 1, "R12 irq raised", rx_irq, 1);
        rx_ie = 1'b0;
        @(negedge clk);
        check(rx_irq == 0, "R12 irq masked", rx_irq, 0);
        rx_ie = 1'b1;

        // R11: arm reader, done clears, next start drops reader-run
        rdr_arm = 1'b1;
        @(negedge clk);
        rdr_arm = 1'b0;
        @(negedge clk);
        check(rdr_run == 1 && rx_done == 0, "R11 arm sets run, clears done",
              {rdr_run, rx_done}, 2'b10);
        check(rx_irq == 0, "R12 irq follows cleared done", rx_irq, 0);
        send(8'h6B, 0, 0, 1);
        check(rdr_run == 0 && rx_data == 8'h6B, "R11 one char admitted",
              {rdr_run, rx_data}, 8'h6B);
        rx_ie = 1'b0;
        pulse_rd();

        // R13: short glitch is rejected
        busy_seen = 0;
        rx_line = 1'b0;
        repeat (5) @(negedge clk);
        rx_line = 1'b1;
        repeat (40) @(negedge clk);
        check(busy_seen == 0, "R13 glitch no busy", busy_seen, 0);
        check(rx_done == 0, "R13 glitch no char", rx_done, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule